// File: doc/BRIEF.md
# Boot Region Write Guard

This block decides whether a sector program or a whole-chip erase may change the storage array. Each request is carried by a write strobe built from the chip enable, write enable and output enable pins. The strobe has to outlast a glitch filter, and it has to end cleanly, with output enable still high. The block then weighs the request and raises a one-cycle `permit` pulse or a one-cycle `refuse` pulse.

Two protected boot regions sit at the bottom and the top of the address space, each 16 KB wide (`2**BOOT_LOG2` bytes). A pre-decoded arm command can lock either region on its own. A locked region stays locked until a separate test reset, which stands in for non-volatile storage. While either region is locked, whole-chip erase is refused. The same storage programming is also held off while the supply is not good, and for a parameterised delay after it becomes good.

An identification read path reports each region's lock state at two fixed addresses. Upstream command decoding supplies the arm pulses, the erase flag and the identification-mode flag.

Top module: `boot_guard`

## Requirements
- R1: Sectors `0 .. 2**(BOOT_LOG2-SECTOR_LOG2)-1` form the low region (indices 0..63 by default). The same number of highest sector indices form the high region (1984..2047 by default). An `arm_low` or `arm_high` pulse, sampled while power is ready, locks only its own region.
- R2: A lock bit, once set, stays set through any command and through `rst`. Only `lock_rst` clears both lock bits.
- R3: A program event to a sector inside a locked region gives `refuse` and no `permit`. A program event to any sector outside the locked regions gives `permit`.
- R4: A program event with `chip_erase_req`=1 is refused when either region is locked, and permitted when neither is.
- R5: With `id_mode`=1, `id_addr`=0x00002 reports the low region and `id_addr`=0x7FFF2 reports the high region. Each reads `id_hit`=1 and `id_data`=0xFE when the region is open, 0xFF when it is locked. Any other address, or `id_mode`=0, reads `id_hit`=0 and `id_data`=0x00.
- R6: The strobe is active when `ce_n`=0, `we_n`=0 and `oe_n`=1. An event occurs at the first rising clock edge that samples the strobe inactive after at least `MIN_PULSE` consecutive active samples, provided `oe_n`=1 at that edge. Exactly one of `permit`/`refuse` is then high for exactly the following cycle.
- R7: A strobe held active for fewer than `MIN_PULSE` samples produces neither `permit` nor `refuse`.
- R8: A qualified strobe that ends with `oe_n`=0 produces neither `permit` nor `refuse`.
- R9: An event is refused while `supply_good`=0, or before `POR_CYCLES` consecutive edges with `supply_good`=1 have been counted. Arm pulses are ignored in that state.
- R10: `rst` clears `permit`, `refuse`, the strobe filter and the power-on timer. The timer then counts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (volatile state) |
| lock_rst | input | 1 | Test reset that clears the lock bits |
| supply_good | input | 1 | Supply level is within range |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| sector_addr | input | ADDR_W-SECTOR_LOG2 | Sector index of the pending request |
| chip_erase_req | input | 1 | Pending request is a whole-chip erase |
| arm_low | input | 1 | Pre-decoded command: lock the low region |
| arm_high | input | 1 | Pre-decoded command: lock the high region |
| id_mode | input | 1 | Identification read mode |
| id_addr | input | ADDR_W | Byte address of the identification read |
| permit | output | 1 | One-cycle pulse: request may change the array |
| refuse | output | 1 | One-cycle pulse: request was rejected |
| id_hit | output | 1 | Identification address is a lock-status location |
| id_data | output | 8 | Lock-status byte |

## Verification
The hardest case to reach is a strobe that passes the glitch filter and is then spoiled at its very last edge. In that case output enable falls in the same cycle that the enables release, so no event may follow. The stimulus releases `we_n` and `ce_n` and lowers `oe_n` on one negative clock edge, after a hold that meets the filter length. The bench also confirms that the lock bits survive a full `rst`. It does this by reading the identification bytes right after reset, while the power-on timer is still running, and by showing that a request made in that window is refused rather than permitted.

// File: rtl/bg_pkg.sv
package bg_pkg;

    typedef enum logic [1:0] {
        V_NONE   = 2'd0,
        V_PERMIT = 2'd1,
        V_REFUSE = 2'd2
    } verdict_e;

    typedef struct packed {
        logic lo;
        logic hi;
    } lock_pair_t;

    localparam logic [7:0] ID_OPEN   = 8'hFE;
    localparam logic [7:0] ID_LOCKED = 8'hFF;
    localparam logic [7:0] ID_NONE   = 8'h00;

    function automatic logic [7:0] status_byte(input logic locked);
        return locked ? ID_LOCKED : ID_OPEN;
    endfunction

endpackage

// File: rtl/bg_strobe_filter.sv
module bg_strobe_filter #(
    parameter int MIN_PULSE = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic fire
);
    localparam int CW = $clog2(MIN_PULSE + 1);
    localparam logic [CW-1:0] FULL = CW'(MIN_PULSE);

    logic          active;
    logic [CW-1:0] run_cnt;

    assign active = !ce_n && !we_n && oe_n;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            run_cnt <= '0;
        end else if (run_cnt != FULL) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // Qualified strobe ends cleanly only if output enable is still high.
    assign fire = (run_cnt == FULL) && !active && oe_n;

endmodule

// File: rtl/bg_power_hold.sv
module bg_power_hold #(
    parameter int POR_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_good,
    output logic ready
);
    localparam int TW = $clog2(POR_CYCLES + 1);
    localparam logic [TW-1:0] DONE = TW'(POR_CYCLES);

    logic [TW-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst || !supply_good) begin
            wait_cnt <= '0;
        end else if (wait_cnt != DONE) begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    assign ready = supply_good && (wait_cnt == DONE);

endmodule

// File: rtl/bg_lock_bits.sv
module bg_lock_bits
    import bg_pkg::*;
(
    input  logic       clk,
    input  logic       lock_rst,
    input  logic       set_lo,
    input  logic       set_hi,
    output lock_pair_t locks
);
    always_ff @(posedge clk) begin
        if (lock_rst) begin
            locks <= '0;
        end else begin
            locks.lo <= locks.lo | set_lo;
            locks.hi <= locks.hi | set_hi;
        end
    end

    assert_lock_lo_sticky_R2: assert property (@(posedge clk) disable iff (lock_rst)
        locks.lo |=> locks.lo);
    assert_lock_hi_sticky_R2: assert property (@(posedge clk) disable iff (lock_rst)
        locks.hi |=> locks.hi);

endmodule

// File: rtl/boot_guard.sv
module boot_guard
    import bg_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int SECTOR_LOG2 = 8,
    parameter int BOOT_LOG2   = 14,
    parameter int MIN_PULSE   = 2,
    parameter int POR_CYCLES  = 500000
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          lock_rst,
    input  logic                          supply_good,
    input  logic                          ce_n,
    input  logic                          we_n,
    input  logic                          oe_n,
    input  logic [ADDR_W-SECTOR_LOG2-1:0] sector_addr,
    input  logic                          chip_erase_req,
    input  logic                          arm_low,
    input  logic                          arm_high,
    input  logic                          id_mode,
    input  logic [ADDR_W-1:0]             id_addr,
    output logic                          permit,
    output logic                          refuse,
    output logic                          id_hit,
    output logic [7:0]                    id_data
);
    localparam int SEC_W = ADDR_W - SECTOR_LOG2;
    localparam logic [SEC_W:0] LOW_LIMIT  = (SEC_W+1)'(2 ** (BOOT_LOG2 - SECTOR_LOG2));
    localparam logic [SEC_W:0] HIGH_START = (SEC_W+1)'(2 ** SEC_W) - LOW_LIMIT;
    localparam logic [ADDR_W-1:0] ID_LO_ADDR = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] ID_HI_ADDR = {ADDR_W{1'b1}} ^ ADDR_W'(4'hD);

    logic       fire;
    logic       ready;
    lock_pair_t locks;
    logic       in_low, in_high, blocked;
    verdict_e   verdict;

    bg_strobe_filter #(.MIN_PULSE(MIN_PULSE)) u_filter (
        .clk  (clk),
        .rst  (rst),
        .ce_n (ce_n),
        .we_n (we_n),
        .oe_n (oe_n),
        .fire (fire)
    );

    bg_power_hold #(.POR_CYCLES(POR_CYCLES)) u_power (
        .clk         (clk),
        .rst         (rst),
        .supply_good (supply_good),
        .ready       (ready)
    );

    bg_lock_bits u_locks (
        .clk      (clk),
        .lock_rst (lock_rst),
        .set_lo   (arm_low && ready),
        .set_hi   (arm_high && ready),
        .locks    (locks)
    );

    assign in_low  = {1'b0, sector_addr} < LOW_LIMIT;
    assign in_high = {1'b0, sector_addr} >= HIGH_START;

    always_comb begin
        blocked = !ready;
        if (chip_erase_req) begin
            blocked = blocked || locks.lo || locks.hi;
        end else begin
            blocked = blocked || (in_low && locks.lo) || (in_high && locks.hi);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict <= V_NONE;
        end else if (fire) begin
            verdict <= blocked ? V_REFUSE : V_PERMIT;
        end else begin
            verdict <= V_NONE;
        end
    end

    assign permit = (verdict == V_PERMIT);
    assign refuse = (verdict == V_REFUSE);

    always_comb begin
        id_hit  = 1'b0;
        id_data = ID_NONE;
        if (id_mode && id_addr == ID_LO_ADDR) begin
            id_hit  = 1'b1;
            id_data = status_byte(locks.lo);
        end else if (id_mode && id_addr == ID_HI_ADDR) begin
            id_hit  = 1'b1;
            id_data = status_byte(locks.hi);
        end
    end

    assert_low_lock_refused_R3: assert property (@(posedge clk) disable iff (rst || lock_rst)
        (fire && !chip_erase_req && locks.lo && in_low) |=> (refuse && !permit));
    assert_erase_locked_R4: assert property (@(posedge clk) disable iff (rst || lock_rst)
        (fire && chip_erase_req && (locks.lo || locks.hi)) |=> refuse);
    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        (permit || refuse) |=> !(permit || refuse));
    assert_oe_clean_end_R8: assert property (@(posedge clk) disable iff (rst)
        (permit || refuse) |-> $past(oe_n));
    assert_no_supply_no_permit_R9: assert property (@(posedge clk) disable iff (rst)
        !supply_good |=> !permit);

endmodule

// File: tb/test_boot_guard.sv
module test_boot_guard;
    localparam int SW = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lock_rst = 1'b1;
    logic supply_good = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [SW-1:0] sector_addr = '0;
    logic chip_erase_req = 1'b0;
    logic arm_low = 1'b0, arm_high = 1'b0;
    logic id_mode = 1'b0;
    logic [18:0] id_addr = '0;
    logic permit, refuse, id_hit;
    logic [7:0] id_data;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    boot_guard #(.MIN_PULSE(3), .POR_CYCLES(20)) i_boot_guard (
        .clk(clk), .rst(rst), .lock_rst(lock_rst), .supply_good(supply_good),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .sector_addr(sector_addr),
        .chip_erase_req(chip_erase_req), .arm_low(arm_low), .arm_high(arm_high),
        .id_mode(id_mode), .id_addr(id_addr), .permit(permit), .refuse(refuse),
        .id_hit(id_hit), .id_data(id_data)
    );

    typedef struct packed {
        logic [SW-1:0] sec;
        logic          erase;
        logic [3:0]    len;
        logic          abort;
        logic          exp_p;
        logic          exp_r;
    } vec_t;

    // Walked with the low region locked and the high region open.
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{11'd0,    1'b0, 4'd3, 1'b0, 1'b0, 1'b1},  // R3 first low sector
        '{11'd63,   1'b0, 4'd3, 1'b0, 1'b0, 1'b1},  // R3 last low sector
        '{11'd64,   1'b0, 4'd3, 1'b0, 1'b1, 1'b0},  // R3 just above low region
        '{11'd1984, 1'b0, 4'd3, 1'b0, 1'b1, 1'b0},  // R1 high region still open
        '{11'd2047, 1'b0, 4'd5, 1'b0, 1'b1, 1'b0},  // R6 longer strobe
        '{11'd500,  1'b1, 4'd3, 1'b0, 1'b0, 1'b1},  // R4 erase with a lock
        '{11'd64,   1'b0, 4'd2, 1'b0, 1'b0, 1'b0},  // R7 short strobe
        '{11'd0,    1'b0, 4'd2, 1'b0, 1'b0, 1'b0},  // R7 short strobe, locked sector
        '{11'd64,   1'b0, 4'd4, 1'b1, 1'b0, 1'b0},  // R8 oe_n low at release
        '{11'd1000, 1'b0, 4'd3, 1'b0, 1'b1, 1'b0}   // R6 mid-array sector
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse(input int len, input logic [SW-1:0] sec, input logic erase,
                         input logic abort, input logic ep, input logic er, input string tag);
        @(negedge clk);
        sector_addr = sec; chip_erase_req = erase;
        oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        repeat (len) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        if (abort) oe_n = 1'b0;
        @(negedge clk);
        chk(permit == ep && refuse == er, tag, {permit, refuse}, {ep, er});
        oe_n = 1'b1;
        @(negedge clk);
        if (ep || er)
            chk(!permit && !refuse, "R6 pulse lasts one cycle", {permit, refuse}, 0);
        chip_erase_req = 1'b0;
    endtask

    task automatic id_read(input logic [18:0] a, input logic eh, input logic [7:0] ed,
                           input string tag);
        @(negedge clk);
        id_mode = 1'b1; id_addr = a;
        #1;
        chk(id_hit == eh && id_data == ed, tag, {id_hit, id_data}, {eh, ed});
        id_mode = 1'b0;
    endtask

    task automatic arm(input logic lo, input logic hi);
        @(negedge clk);
        arm_low = lo; arm_high = hi;
        @(negedge clk);
        arm_low = 1'b0; arm_high = 1'b0;
    endtask

    initial begin : watchdog
        #2000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0; lock_rst = 1'b0;
        @(negedge clk);
        chk(!permit && !refuse, "R10 reset outputs", {permit, refuse}, 0);
        id_read(19'h00002, 1'b1, 8'hFE, "R5 low open after lock_rst");
        id_read(19'h7FFF2, 1'b1, 8'hFE, "R5 high open after lock_rst");

        pulse(3, 11'd100, 1'b0, 1'b0, 1'b0, 1'b1, "R9 refused without supply");
        arm(1'b1, 1'b1);
        id_read(19'h00002, 1'b1, 8'hFE, "R9 arm ignored without supply");

        supply_good = 1'b1;
        repeat (3) @(negedge clk);
        pulse(3, 11'd100, 1'b0, 1'b0, 1'b0, 1'b1, "R9 refused during power-on delay");
        repeat (25) @(negedge clk);
        pulse(3, 11'd100, 1'b0, 1'b0, 1'b1, 1'b0, "R6 permit after delay");
        pulse(3, 11'd0, 1'b1, 1'b0, 1'b1, 1'b0, "R4 erase with no lock");

        arm(1'b1, 1'b0);
        id_read(19'h00002, 1'b1, 8'hFF, "R1 low locked");
        id_read(19'h7FFF2, 1'b1, 8'hFE, "R1 high untouched");

        for (int i = 0; i < NV; i++) begin
            pulse(int'(VECS[i].len), VECS[i].sec, VECS[i].erase, VECS[i].abort,
                  VECS[i].exp_p, VECS[i].exp_r, $sformatf("vector %0d R3/R4/R6/R7/R8", i));
        end

        arm(1'b0, 1'b1);
        id_read(19'h7FFF2, 1'b1, 8'hFF, "R5 high locked");
        pulse(3, 11'd1984, 1'b0, 1'b0, 1'b0, 1'b1, "R3 high region refused");
        pulse(3, 11'd1983, 1'b0, 1'b0, 1'b1, 1'b0, "R3 below high region permitted");
        id_read(19'h00003, 1'b0, 8'h00, "R5 other address");
        @(negedge clk);
        id_mode = 1'b0; id_addr = 19'h00002; #1;
        chk(!id_hit && id_data == 8'h00, "R5 id_mode low", {id_hit, id_data}, 0);

        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(!permit && !refuse, "R10 outputs after rst", {permit, refuse}, 0);
        id_read(19'h00002, 1'b1, 8'hFF, "R2 low lock survives rst");
        id_read(19'h7FFF2, 1'b1, 8'hFF, "R2 high lock survives rst");
        pulse(3, 11'd100, 1'b0, 1'b0, 1'b0, 1'b1, "R10 timer restarted by rst");

        repeat (25) @(negedge clk);
        supply_good = 1'b0;
        pulse(3, 11'd100, 1'b0, 1'b0, 1'b0, 1'b1, "R9 supply dropped");

        @(negedge clk); lock_rst = 1'b1;
        @(negedge clk); lock_rst = 1'b0;
        id_read(19'h00002, 1'b1, 8'hFE, "R2 lock_rst clears low");
        id_read(19'h7FFF2, 1'b1, 8'hFE, "R2 lock_rst clears high");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule